// File: doc/BRIEF.md
# Two-Wire Register Access Slave with Pointer Auto-Increment

This block is the bus-side front end of a small bank of 8-bit registers. It watches the two open-drain lines of an I2C-compatible bus, with the clock and data inputs brought into the system clock domain. It pulls the data line low through an output enable when it acknowledges or sends a zero bit. It answers to one fixed 7-bit device address. It keeps a byte-wide register pointer and drives a plain read-data / write-strobe port toward a neighbouring register file. That register file owns the register contents and their defaults.

In a write transfer the first byte after the device address sets the pointer, and every later byte is written to the pointed register before the pointer steps forward. In a read transfer the pointed register is shifted out MSB first. The master's acknowledge advances the pointer to the next register, and a not-acknowledge ends the transfer. A STOP always returns the pointer to register 0, so a status register at 0 can be polled with bare read transfers. Two commands ask the register file to restore its defaults: a general-call write carrying a configurable code, and a write of a reserved pointer value. The block flags a read burst in progress, so the neighbour can hold its data registers steady while several bytes are fetched.

Top module: `twi_regport`

## Requirements
- R1: After reset, sda_oe, reg_wr, rd_active and soft_rst are 0 and reg_addr is 0.
- R2: An address byte equal to DEV_ADDR followed by R/W (write byte 0x90, read byte 0x91 at the default 0x48) is acknowledged by pulling SDA low during the ninth SCL high phase. Any other address byte, except the general call, is not acknowledged, and the slave then releases SDA and ignores all bytes until the next START.
- R3: In a write transfer the first byte after the address byte loads the pointer, and reg_addr shows the loaded value.
- R4: Each later write byte is acknowledged and produces a single-cycle reg_wr pulse, with reg_wdata equal to the byte and reg_addr equal to the pointer. The pointer then increases by one.
- R5: A STOP returns the slave to idle and sets the pointer to 0, including at the end of a read. A read transfer opened right after a STOP therefore returns register 0.
- R6: A repeated START restarts address reception exactly as a START does, and the pointer set before it is kept.
- R7: In a read transfer the byte on reg_rdata for the current pointer is sent MSB first. A master ACK (SDA low in the ninth bit) advances the pointer and sends the next register. A master NACK releases SDA and leaves the pointer unchanged.
- R8: A write byte whose pointer is NUM_REGS or above is still acknowledged, but no reg_wr pulse is issued.
- R9: Reads continue past the last register: the pointer keeps increasing and reg_rdata is sent for every pointer value until NACK, START or STOP.
- R10: The general-call byte 0x00 is acknowledged. A following data byte equal to GC_CODE (default 0x06) is acknowledged, gives one soft_rst pulse and sets the pointer to 0. Any other data byte is not acknowledged and gives no pulse.
- R11: Writing the pointer value RST_CMD (default 0xBF) gives one soft_rst pulse and sets the pointer to 0.
- R12: rd_active is high from the end of the read-address acknowledge until the read ends by NACK, START or STOP, and reg_wr never pulses while it is high.
- R13: sda_oe changes only while SCL is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Bus clock line level |
| sda_i | input | 1 | Bus data line level |
| sda_oe | output | 1 | 1 pulls the data line low |
| reg_addr | output | 8 | Current register pointer |
| reg_rdata | input | 8 | Register contents at reg_addr |
| reg_wr | output | 1 | Single-cycle write strobe |
| reg_wdata | output | 8 | Write data, valid with reg_wr |
| rd_active | output | 1 | Read burst in progress |
| soft_rst | output | 1 | Single-cycle request to restore register defaults |

## Verification
The bench builds the block with its defaults: device address 0x48, 19 registers, general-call code 0x06, reset pointer 0xBF and a two-stage synchroniser. With 19 registers, random burst start points up to four past the end reach both invalid-write discards and reads past the last register within short bursts. The bus quarter period of five system clocks leaves only a small margin over the synchroniser plus edge-detect latency, so acknowledge timing and SDA hand-over at SCL falling edges are exercised close to their limit.

// File: rtl/twi_pkg.sv
package twi_pkg;
  localparam int BYTE_W = 8;

  typedef enum logic [2:0] {
    M_IDLE,
    M_ADDR,
    M_PTR,
    M_WDATA,
    M_GCALL,
    M_READ,
    M_SKIP
  } twi_mode_e;
endpackage

// File: rtl/twi_line_sync.sv
module twi_line_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_det,
  output logic stop_det
);
  logic [STAGES-1:0] scl_ff;
  logic [STAGES-1:0] sda_ff;
  logic scl_d;
  logic sda_d;
  logic scl_s;

  // synchroniser chain, idle bus level is high
  genvar g;
  generate
    for (g = 0; g < STAGES; g++) begin : g_stage
      if (g == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) begin
            scl_ff[0] <= 1'b1;
            sda_ff[0] <= 1'b1;
          end else begin
            scl_ff[0] <= scl_i;
            sda_ff[0] <= sda_i;
          end
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) begin
            scl_ff[g] <= 1'b1;
            sda_ff[g] <= 1'b1;
          end else begin
            scl_ff[g] <= scl_ff[g-1];
            sda_ff[g] <= sda_ff[g-1];
          end
        end
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_d <= 1'b1;
      sda_d <= 1'b1;
    end else begin
      scl_d <= scl_s;
      sda_d <= sda_s;
    end
  end

  assign scl_s     = scl_ff[STAGES-1];
  assign sda_s     = sda_ff[STAGES-1];
  assign scl_rise  = scl_s & ~scl_d;
  assign scl_fall  = ~scl_s & scl_d;
  assign start_det = scl_s & scl_d & sda_d & ~sda_s;
  assign stop_det  = scl_s & scl_d & ~sda_d & sda_s;
endmodule

// File: rtl/twi_ptr_unit.sv
module twi_ptr_unit #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         load,
  input  logic [W-1:0] load_val,
  input  logic         inc,
  output logic [W-1:0] ptr
);
  logic [W-1:0] ptr_q;
  logic [W-1:0] ptr_n;

  always_comb begin
    ptr_n = ptr_q;
    if (clr)       ptr_n = '0;
    else if (load) ptr_n = load_val;
    else if (inc)  ptr_n = ptr_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ptr_q <= '0;
    else        ptr_q <= ptr_n;
  end

  assign ptr = ptr_q;
endmodule

// File: rtl/twi_proto_fsm.sv
module twi_proto_fsm
  import twi_pkg::*;
#(
  parameter logic [6:0] DEV_ADDR = 7'h48,
  parameter int         NUM_REGS = 19,
  parameter logic [7:0] GC_CODE  = 8'h06,
  parameter logic [7:0] RST_CMD  = 8'hBF
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scl_rise,
  input  logic              scl_fall,
  input  logic              start_det,
  input  logic              stop_det,
  input  logic              sda_s,
  input  logic [BYTE_W-1:0] ptr,
  input  logic [BYTE_W-1:0] rdata,
  output logic              ptr_clr,
  output logic              ptr_load,
  output logic [BYTE_W-1:0] ptr_val,
  output logic              ptr_inc,
  output logic              reg_wr,
  output logic [BYTE_W-1:0] reg_wdata,
  output logic              soft_rst,
  output logic              sda_oe,
  output logic              rd_active
);
  localparam logic [3:0]      BITS  = 4'(BYTE_W);
  localparam logic [BYTE_W:0] LIMIT = (BYTE_W+1)'(NUM_REGS);

  twi_mode_e         mode_q, mode_n;
  logic [3:0]        cnt_q, cnt_n;
  logic              ackph_q, ackph_n;
  logic              ackdrv_q, ackdrv_n;
  logic              mack_q, mack_n;
  logic [BYTE_W-1:0] sh_q, sh_n;
  logic [BYTE_W-1:0] tx_q, tx_n;
  logic              wr_q, wr_n;
  logic              srst_q, srst_n;
  logic              oe_q, oe_n;
  logic              addr_hit;
  logic              gcall_hit;
  logic              ptr_valid;

  assign addr_hit  = (sh_q[7:1] == DEV_ADDR);
  assign gcall_hit = (sh_q == 8'h00);
  assign ptr_valid = ({1'b0, ptr} < LIMIT);
  assign ptr_val   = sh_q;

  // next-state logic
  always_comb begin
    mode_n   = mode_q;
    cnt_n    = cnt_q;
    ackph_n  = ackph_q;
    ackdrv_n = ackdrv_q;
    mack_n   = mack_q;
    sh_n     = sh_q;
    tx_n     = tx_q;
    wr_n     = 1'b0;
    srst_n   = 1'b0;
    ptr_clr  = 1'b0;
    ptr_load = 1'b0;
    ptr_inc  = 1'b0;

    if (start_det) begin
      mode_n   = M_ADDR;
      cnt_n    = '0;
      ackph_n  = 1'b0;
      ackdrv_n = 1'b0;
    end else if (stop_det) begin
      mode_n   = M_IDLE;
      cnt_n    = '0;
      ackph_n  = 1'b0;
      ackdrv_n = 1'b0;
      ptr_clr  = 1'b1;
    end else begin
      case (mode_q)
        M_ADDR, M_PTR, M_WDATA, M_GCALL: begin
          if (!ackph_q) begin
            if (scl_rise && cnt_q != BITS) begin
              sh_n  = {sh_q[BYTE_W-2:0], sda_s};
              cnt_n = cnt_q + 1'b1;
            end else if (scl_fall && cnt_q == BITS) begin
              ackph_n = 1'b1;
              case (mode_q)
                M_ADDR:  ackdrv_n = addr_hit | gcall_hit;
                M_PTR: begin
                  ackdrv_n = 1'b1;
                  if (sh_q == RST_CMD) begin
                    srst_n  = 1'b1;
                    ptr_clr = 1'b1;
                  end else begin
                    ptr_load = 1'b1;
                  end
                end
                M_WDATA: begin
                  ackdrv_n = 1'b1;
                  wr_n     = ptr_valid;
                end
                default: begin
                  ackdrv_n = (sh_q == GC_CODE);
                  if (sh_q == GC_CODE) begin
                    srst_n  = 1'b1;
                    ptr_clr = 1'b1;
                  end
                end
              endcase
            end
          end else if (scl_fall) begin
            ackph_n  = 1'b0;
            ackdrv_n = 1'b0;
            cnt_n    = '0;
            case (mode_q)
              M_ADDR: begin
                if (addr_hit && sh_q[0]) begin
                  mode_n = M_READ;
                  tx_n   = rdata;
                end else if (addr_hit) begin
                  mode_n = M_PTR;
                end else if (gcall_hit) begin
                  mode_n = M_GCALL;
                end else begin
                  mode_n = M_SKIP;
                end
              end
              M_PTR:   mode_n  = M_WDATA;
              M_WDATA: ptr_inc = 1'b1;
              default: mode_n  = M_SKIP;
            endcase
          end
        end
        M_READ: begin
          if (!ackph_q) begin
            if (scl_rise) begin
              cnt_n = cnt_q + 1'b1;
            end else if (scl_fall) begin
              if (cnt_q == BITS) ackph_n = 1'b1;
              else               tx_n    = {tx_q[BYTE_W-2:0], 1'b1};
            end
          end else begin
            if (scl_rise) begin
              mack_n  = ~sda_s;
              ptr_inc = ~sda_s;
            end else if (scl_fall) begin
              ackph_n = 1'b0;
              cnt_n   = '0;
              if (mack_q) tx_n   = rdata;
              else        mode_n = M_SKIP;
            end
          end
        end
        default: ;
      endcase
    end

    if (mode_n == M_READ) oe_n = ~ackph_n & ~tx_n[BYTE_W-1];
    else                  oe_n = ackph_n & ackdrv_n;
  end

  // state registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q   <= M_IDLE;
      cnt_q    <= '0;
      ackph_q  <= 1'b0;
      ackdrv_q <= 1'b0;
      mack_q   <= 1'b0;
      sh_q     <= '0;
      tx_q     <= '1;
      wr_q     <= 1'b0;
      srst_q   <= 1'b0;
      oe_q     <= 1'b0;
    end else begin
      mode_q   <= mode_n;
      cnt_q    <= cnt_n;
      ackph_q  <= ackph_n;
      ackdrv_q <= ackdrv_n;
      mack_q   <= mack_n;
      sh_q     <= sh_n;
      tx_q     <= tx_n;
      wr_q     <= wr_n;
      srst_q   <= srst_n;
      oe_q     <= oe_n;
    end
  end

  assign reg_wr    = wr_q;
  assign reg_wdata = sh_q;
  assign soft_rst  = srst_q;
  assign sda_oe    = oe_q;
  assign rd_active = (mode_q == M_READ);
endmodule

// File: rtl/twi_regport.sv
module twi_regport
  import twi_pkg::*;
#(
  parameter logic [6:0] DEV_ADDR    = 7'h48,
  parameter int         NUM_REGS    = 19,
  parameter logic [7:0] GC_CODE     = 8'h06,
  parameter logic [7:0] RST_CMD     = 8'hBF,
  parameter int         SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       scl_i,
  input  logic       sda_i,
  output logic       sda_oe,
  output logic [7:0] reg_addr,
  input  logic [7:0] reg_rdata,
  output logic       reg_wr,
  output logic [7:0] reg_wdata,
  output logic       rd_active,
  output logic       soft_rst
);
  logic rst_meta;
  logic rst_core_n;

  // asynchronous assert, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta   <= 1'b0;
      rst_core_n <= 1'b0;
    end else begin
      rst_meta   <= 1'b1;
      rst_core_n <= rst_meta;
    end
  end

  logic sda_s, scl_rise, scl_fall, start_det, stop_det;
  logic ptr_clr, ptr_load, ptr_inc;
  logic [BYTE_W-1:0] ptr_val;
  logic [BYTE_W-1:0] ptr;

  twi_line_sync #(.STAGES(SYNC_STAGES)) sync_i (
    .clk       (clk),
    .rst_n     (rst_core_n),
    .scl_i     (scl_i),
    .sda_i     (sda_i),
    .sda_s     (sda_s),
    .scl_rise  (scl_rise),
    .scl_fall  (scl_fall),
    .start_det (start_det),
    .stop_det  (stop_det)
  );

  twi_ptr_unit #(.W(BYTE_W)) ptr_i (
    .clk      (clk),
    .rst_n    (rst_core_n),
    .clr      (ptr_clr),
    .load     (ptr_load),
    .load_val (ptr_val),
    .inc      (ptr_inc),
    .ptr      (ptr)
  );

  twi_proto_fsm #(
    .DEV_ADDR (DEV_ADDR),
    .NUM_REGS (NUM_REGS),
    .GC_CODE  (GC_CODE),
    .RST_CMD  (RST_CMD)
  ) fsm_i (
    .clk       (clk),
    .rst_n     (rst_core_n),
    .scl_rise  (scl_rise),
    .scl_fall  (scl_fall),
    .start_det (start_det),
    .stop_det  (stop_det),
    .sda_s     (sda_s),
    .ptr       (ptr),
    .rdata     (reg_rdata),
    .ptr_clr   (ptr_clr),
    .ptr_load  (ptr_load),
    .ptr_val   (ptr_val),
    .ptr_inc   (ptr_inc),
    .reg_wr    (reg_wr),
    .reg_wdata (reg_wdata),
    .soft_rst  (soft_rst),
    .sda_oe    (sda_oe),
    .rd_active (rd_active)
  );

  assign reg_addr = ptr;
endmodule

// File: rtl/twi_regport_chk.sv
module twi_regport_chk #(
  parameter int NUM_REGS = 19
) (
  input logic       clk,
  input logic       rst_n,
  input logic       scl_i,
  input logic       sda_oe,
  input logic [7:0] reg_addr,
  input logic       reg_wr,
  input logic       rd_active,
  input logic       soft_rst
);
  localparam logic [8:0] LIMIT = 9'(NUM_REGS);

  assert_wr_in_range_R8: assert property (@(posedge clk) disable iff (!rst_n)
    reg_wr |-> ({1'b0, reg_addr} < LIMIT));

  assert_wr_single_R4: assert property (@(posedge clk) disable iff (!rst_n)
    reg_wr |=> !reg_wr);

  assert_srst_ptr_zero_R11: assert property (@(posedge clk) disable iff (!rst_n)
    soft_rst |-> (reg_addr == 8'h00));

  assert_srst_single_R10: assert property (@(posedge clk) disable iff (!rst_n)
    soft_rst |=> !soft_rst);

  assert_no_wr_in_read_R12: assert property (@(posedge clk) disable iff (!rst_n)
    rd_active |-> !reg_wr);

  assert_oe_moves_scl_low_R13: assert property (@(posedge clk) disable iff (!rst_n)
    (sda_oe != $past(sda_oe)) |-> !scl_i);
endmodule

bind twi_regport twi_regport_chk #(.NUM_REGS(NUM_REGS)) chk_i (
  .clk       (clk),
  .rst_n     (rst_n),
  .scl_i     (scl_i),
  .sda_oe    (sda_oe),
  .reg_addr  (reg_addr),
  .reg_wr    (reg_wr),
  .rd_active (rd_active),
  .soft_rst  (soft_rst)
);

// File: tb/twi_regport_tb_top.sv
module twi_regport_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int Q          = 5;
  localparam int NREG       = 19;
  localparam logic [7:0] WR_BYTE = 8'h90;
  localparam logic [7:0] RD_BYTE = 8'h91;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl_m = 1'b1;
  logic sda_m = 1'b1;
  logic sda_oe, reg_wr, rd_active, soft_rst;
  logic [7:0] reg_addr, reg_rdata, reg_wdata;
  wire  sda_line = sda_m & ~sda_oe;

  int checks = 0;
  int errors = 0;
  int bad_wr = 0;
  int srst_cnt = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  twi_regport dut_i (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_line),
    .sda_oe(sda_oe), .reg_addr(reg_addr), .reg_rdata(reg_rdata),
    .reg_wr(reg_wr), .reg_wdata(reg_wdata), .rd_active(rd_active),
    .soft_rst(soft_rst)
  );

  function automatic logic [7:0] dflt(int i);
    return 8'(i * 37 + 11);
  endfunction

  // neighbouring register file
  logic [7:0] mem [NREG];
  logic [7:0] exp_m [NREG];

  always @(posedge clk) begin
    if (!rst_n || soft_rst) begin
      for (int i = 0; i < NREG; i++) mem[i] <= dflt(i);
    end else if (reg_wr) begin
      if (reg_addr < NREG) mem[reg_addr] <= reg_wdata;
    end
    if (rst_n && reg_wr && reg_addr >= NREG) bad_wr++;
    if (rst_n && soft_rst) srst_cnt++;
  end

  assign reg_rdata = (reg_addr < NREG) ? mem[reg_addr] : (reg_addr ^ 8'h5A);

  function automatic logic [7:0] exp_rd(int a);
    if (a < NREG) return exp_m[a];
    return 8'(a) ^ 8'h5A;
  endfunction

  task automatic exp_defaults();
    for (int i = 0; i < NREG; i++) exp_m[i] = dflt(i);
  endtask

  task automatic chk(input bit ok, input string req, input int act, input int expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, expv);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bus_start();
    sda_m = 1'b1; tick(Q);
    scl_m = 1'b1; tick(Q);
    sda_m = 1'b0; tick(Q);
    scl_m = 1'b0; tick(Q);
  endtask

  task automatic bus_stop();
    sda_m = 1'b0; tick(Q);
    scl_m = 1'b1; tick(Q);
    sda_m = 1'b1; tick(Q);
  endtask

  // returns the line level in the ninth bit: 0 means acknowledged
  task automatic send_byte(input logic [7:0] b, output logic nack);
    for (int i = 7; i >= 0; i--) begin
      sda_m = b[i]; tick(Q);
      scl_m = 1'b1; tick(2*Q);
      scl_m = 1'b0; tick(Q);
    end
    sda_m = 1'b1; tick(Q);
    scl_m = 1'b1; tick(Q);
    nack = sda_line;
    tick(Q);
    scl_m = 1'b0; tick(Q);
  endtask

  task automatic recv_byte(input logic give_nack, output logic [7:0] b);
    sda_m = 1'b1;
    for (int i = 7; i >= 0; i--) begin
      tick(Q);
      scl_m = 1'b1; tick(Q);
      b[i] = sda_line;
      tick(Q);
      scl_m = 1'b0; tick(Q);
    end
    sda_m = give_nack; tick(Q);
    scl_m = 1'b1; tick(2*Q);
    scl_m = 1'b0; tick(Q);
    sda_m = 1'b1;
  endtask

  task automatic set_ptr_rd(input logic [7:0] p, input string req);
    logic nk;
    bus_start();
    send_byte(WR_BYTE, nk); chk(nk == 0, req, nk, 0);
    send_byte(p, nk);       chk(nk == 0, req, nk, 0);
    bus_start();
    send_byte(RD_BYTE, nk); chk(nk == 0, req, nk, 0);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog actual=0x0 expected=0x1");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic nk;
    logic [7:0] rb;
    int s0;
    void'($urandom(32'h5EED_0042));
    exp_defaults();
    tick(5);
    rst_n = 1'b1;
    tick(6);

    // R1: reset state
    chk(sda_oe == 0 && reg_wr == 0 && rd_active == 0 && soft_rst == 0, "R1", {sda_oe, reg_wr, rd_active, soft_rst}, 0);
    chk(reg_addr == 0, "R1", reg_addr, 0);

    // R2 R3 R4 R5: write burst
    bus_start();
    send_byte(WR_BYTE, nk); chk(nk == 0, "R2", nk, 0);
    send_byte(8'h03, nk);   chk(nk == 0, "R3", nk, 0);
    chk(reg_addr == 8'h03, "R3", reg_addr, 3);
    send_byte(8'hAA, nk);   chk(nk == 0, "R4", nk, 0);
    send_byte(8'hBB, nk);   chk(nk == 0, "R4", nk, 0);
    exp_m[3] = 8'hAA; exp_m[4] = 8'hBB;
    chk(reg_addr == 8'h05, "R4", reg_addr, 5);
    bus_stop(); tick(4);
    chk(reg_addr == 0, "R5", reg_addr, 0);

    // R6 R7 R12: repeated start read, ack then nack
    set_ptr_rd(8'h04, "R6");
    recv_byte(1'b0, rb); chk(rb == exp_rd(4), "R6", rb, exp_rd(4));
    chk(rd_active == 1, "R12", rd_active, 1);
    recv_byte(1'b1, rb); chk(rb == exp_rd(5), "R7", rb, exp_rd(5));
    tick(2);
    chk(rd_active == 0, "R12", rd_active, 0);
    chk(reg_addr == 8'h05, "R7", reg_addr, 5);
    chk(sda_oe == 0, "R7", sda_oe, 0);
    bus_stop(); tick(4);

    // R5: poll register 0 without setting the pointer
    bus_start();
    send_byte(RD_BYTE, nk); chk(nk == 0, "R2", nk, 0);
    recv_byte(1'b1, rb); chk(rb == exp_rd(0), "R5", rb, exp_rd(0));
    bus_stop(); tick(4);
    chk(reg_addr == 0 && rd_active == 0, "R5", reg_addr, 0);

    // R2: foreign address ignored
    bus_start();
    send_byte(8'h92, nk); chk(nk == 1, "R2", nk, 1);
    send_byte(8'h02, nk); chk(nk == 1, "R2", nk, 1);
    send_byte(8'h77, nk); chk(nk == 1, "R2", nk, 1);
    bus_stop(); tick(4);
    set_ptr_rd(8'h02, "R2");
    recv_byte(1'b1, rb); chk(rb == exp_rd(2), "R2", rb, exp_rd(2));
    bus_stop();

    // R8: write beyond the bank is acknowledged but discarded
    bus_start();
    send_byte(WR_BYTE, nk); chk(nk == 0, "R8", nk, 0);
    send_byte(8'd20, nk);   chk(nk == 0, "R8", nk, 0);
    send_byte(8'h33, nk);   chk(nk == 0, "R8", nk, 0);
    bus_stop(); tick(4);
    chk(bad_wr == 0, "R8", bad_wr, 0);

    // R9: read past the last register
    set_ptr_rd(8'd17, "R9");
    for (int a = 17; a < 21; a++) begin
      recv_byte(a == 20, rb); chk(rb == exp_rd(a), "R9", rb, exp_rd(a));
    end
    bus_stop(); tick(4);

    // R10: general call with other code
    s0 = srst_cnt;
    bus_start();
    send_byte(8'h00, nk); chk(nk == 0, "R10", nk, 0);
    send_byte(8'h07, nk); chk(nk == 1, "R10", nk, 1);
    bus_stop(); tick(4);
    chk(srst_cnt == s0, "R10", srst_cnt, s0);

    // R10: general call reset
    bus_start();
    send_byte(8'h00, nk); chk(nk == 0, "R10", nk, 0);
    send_byte(8'h06, nk); chk(nk == 0, "R10", nk, 0);
    bus_stop(); tick(4);
    chk(srst_cnt == s0 + 1, "R10", srst_cnt, s0 + 1);
    exp_defaults();
    set_ptr_rd(8'h03, "R10");
    recv_byte(1'b1, rb); chk(rb == exp_rd(3), "R10", rb, exp_rd(3));
    bus_stop();

    // R11: reset pointer command
    bus_start();
    send_byte(WR_BYTE, nk); send_byte(8'h07, nk); send_byte(8'h11, nk);
    bus_stop();
    exp_m[7] = 8'h11;
    s0 = srst_cnt;
    bus_start();
    send_byte(WR_BYTE, nk); chk(nk == 0, "R11", nk, 0);
    send_byte(8'hBF, nk);   chk(nk == 0, "R11", nk, 0);
    chk(reg_addr == 0, "R11", reg_addr, 0);
    chk(srst_cnt == s0 + 1, "R11", srst_cnt, s0 + 1);
    bus_stop();
    exp_defaults();
    set_ptr_rd(8'h07, "R11");
    recv_byte(1'b1, rb); chk(rb == exp_rd(7), "R11", rb, exp_rd(7));
    bus_stop();

    // random bursts: R4 R7 R8 R9
    for (int it = 0; it < 24; it++) begin
      int p0, len, p;
      logic [7:0] d;
      p0  = $urandom % (NREG + 4);
      len = 1 + $urandom % 4;
      bus_start();
      send_byte(WR_BYTE, nk);
      send_byte(8'(p0), nk);
      p = p0;
      for (int k = 0; k < len; k++) begin
        d = 8'($urandom);
        send_byte(d, nk); chk(nk == 0, "R4", nk, 0);
        if (p < NREG) exp_m[p] = d;
        p++;
      end
      bus_stop();
      set_ptr_rd(8'(p0), "R7");
      for (int k = 0; k < len; k++) begin
        recv_byte(k == len - 1, rb);
        chk(rb == exp_rd(p0 + k), "R7", rb, exp_rd(p0 + k));
      end
      bus_stop(); tick(4);
    end
    chk(bad_wr == 0, "R8", bad_wr, 0);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule